// File: doc/BRIEF.md
# Reversible Full-Cycle LFSR Address Stepper

This block produces the address stream for a memory self-test engine. It is a small shift-register counter that visits every one of its 2^WIDTH addresses, all-zeros included. It can run forwards or backwards, and the backward order is exactly the forward order reversed. A March sequencer can therefore use the same hardware for both its ascending and descending elements. It just flips a direction pin. A terminal flag tells the sequencer that the current address is the final one of a pass in the selected direction.

Inside, the register is a Galois-free, Fibonacci-style LFSR. A NOR correction term splices the zero state into the maximal-length cycle. A 2:1 multiplexer in front of each stage chooses the shift source, either the lower or the upper neighbour. In the forward direction the feedback follows x^3 + x + 1. In the reverse direction it follows the reciprocal polynomial x^3 + x^2 + 1.

The block has no data path, so every pin is a plain control or status signal. The default build is 3 bits wide. Address bit i is stage Xi, so the value 3'b001 means X0=1.

Top module: `lfsr_addr_stepper`

## Requirements
- R1: While `rst` is high at a clock edge, the next `addr` is 0. This takes priority over `load` and `en`.
- R2: With `dir_down`=0 and `en`=1, successive `addr` values (as integers) follow 0, 1, 3, 7, 6, 5, 2, 4 and then wrap to 0.
- R3: With `dir_down`=1 and `en`=1, successive `addr` values follow 4, 2, 5, 6, 7, 3, 1, 0 and then wrap to 4.
- R4: In each direction, 8 consecutive steps from any start visit all 8 addresses, zero included, and return to the start.
- R5: An enabled down step taken right after an enabled up step restores the address held before the up step.
- R6: When `en`=0 and `load`=0, `addr` holds its value, whatever `dir_down` is.
- R7: When `load`=1 and `rst`=0, the next `addr` equals `load_addr`, regardless of `en` and `dir_down`.
- R8: The `last` output is combinational. It is 1 when `dir_down`=0 and `addr`=4, or when `dir_down`=1 and `addr`=0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance one step when high |
| dir_down | input | 1 | 0 = ascending order, 1 = reverse order |
| load | input | 1 | Load `load_addr` on the next edge |
| load_addr | input | WIDTH | Start address to load |
| addr | output | WIDTH | Current address (bit i = stage Xi) |
| last | output | 1 | Current address is the final one for `dir_down` |

## Verification
The assertions expect `rst` to be asserted at the first clock edge. They also expect `en`, `dir_down`, `load` and `load_addr` to be settled well before each rising edge. The bench meets both conditions by holding reset from time zero and by changing every input only on the falling edge. The reversal and terminal properties hold for any legal input mix. The stimulus therefore covers the whole input space, in sweeps over all eight addresses and in a pseudo-random mix, and never needs to filter combinations out.

// File: rtl/addr_step_pkg.sv
package addr_step_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } step_dir_e;
endpackage

// File: rtl/lfsr_updown_next.sv
module lfsr_updown_next
  import addr_step_pkg::*;
#(
  parameter int                 WIDTH = 3,
  // bit j set: stage Xj feeds the forward feedback (besides X[WIDTH-1])
  parameter logic [WIDTH-2:0]   TAPS  = 2'b01
) (
  input  logic [WIDTH-1:0] cur,
  input  step_dir_e        dir,
  output logic [WIDTH-1:0] nxt
);
  localparam int TOP = WIDTH - 1;

  logic zero_low, zero_high, fb_up, fb_dn;

  // forward: NOR over lower stages splices the all-zero state in
  assign zero_low  = ~|cur[TOP-1:0];
  assign fb_up     = cur[TOP] ^ (^(cur[TOP-1:0] & TAPS)) ^ zero_low;
  // reverse: inverse map, taps seen one stage higher
  assign zero_high = ~|cur[TOP:1];
  assign fb_dn     = cur[0] ^ (^(cur[TOP:1] & TAPS)) ^ zero_high;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic src_up, src_dn;
    if (i == 0) begin : g_first
      assign src_up = fb_up;
      assign src_dn = cur[1];
    end else if (i == TOP) begin : g_last
      assign src_up = cur[i-1];
      assign src_dn = fb_dn;
    end else begin : g_mid
      assign src_up = cur[i-1];
      assign src_dn = cur[i+1];
    end
    assign nxt[i] = (dir == DIR_DOWN) ? src_dn : src_up;
  end
endmodule

// File: rtl/lfsr_end_detect.sv
module lfsr_end_detect
  import addr_step_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur,
  input  step_dir_e        dir,
  output logic             last
);
  localparam logic [WIDTH-1:0] UP_END = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] DN_END = '0;

  always_comb begin
    unique case (dir)
      DIR_UP:   last = (cur == UP_END);
      DIR_DOWN: last = (cur == DN_END);
      default:  last = 1'b0;
    endcase
  end
endmodule

// File: rtl/lfsr_addr_stepper.sv
module lfsr_addr_stepper
  import addr_step_pkg::*;
#(
  parameter int               WIDTH = 3,
  parameter logic [WIDTH-2:0] TAPS  = 2'b01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             dir_down,
  input  logic             load,
  input  logic [WIDTH-1:0] load_addr,
  output logic [WIDTH-1:0] addr,
  output logic             last
);
  localparam logic [WIDTH-1:0] UP_END = {1'b1, {(WIDTH-1){1'b0}}};

  step_dir_e        dir;
  logic [WIDTH-1:0] state_q, step_nxt;

  assign dir = step_dir_e'(dir_down);

  lfsr_updown_next #(.WIDTH(WIDTH), .TAPS(TAPS)) u_next (
    .cur(state_q), .dir(dir), .nxt(step_nxt)
  );

  lfsr_end_detect #(.WIDTH(WIDTH)) u_end (
    .cur(state_q), .dir(dir), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst)       state_q <= '0;
    else if (load) state_q <= load_addr;
    else if (en)   state_q <= step_nxt;
  end

  assign addr = state_q;

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (addr == '0));

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(addr));

  // R7
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr == $past(load_addr)));

  // R5
  reverse_undo_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load && !dir_down) ##1 (en && !load && dir_down)
    |=> (addr == $past(addr, 2)));

  // R2
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load && !dir_down && last) |=> (addr == '0));

  // R3
  down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load && dir_down && last) |=> (addr == UP_END));

  // R8
  last_shape_chk: assert property (@(posedge clk) disable iff (rst)
    last |-> ($countones(addr) <= 1));
endmodule

// File: tb/sim_lfsr_addr_stepper.sv
`timescale 1ns/1ps
module sim_lfsr_addr_stepper;
  logic       clk = 1'b0;
  logic       rst, en, dir_down, load;
  logic [2:0] load_addr, addr;
  logic       last;
  int         checks = 0, failures = 0;
  bit         done = 0;
  logic [2:0] exp_addr;
  int         up_seq [8] = '{0, 1, 3, 7, 6, 5, 2, 4};

  always #2 clk = ~clk;

  lfsr_addr_stepper u0 (
    .clk(clk), .rst(rst), .en(en), .dir_down(dir_down), .load(load),
    .load_addr(load_addr), .addr(addr), .last(last)
  );

  function automatic int pos_of(logic [2:0] a);
    for (int k = 0; k < 8; k++) if (up_seq[k] == int'(a)) return k;
    return 0;
  endfunction

  function automatic logic [2:0] model(logic [2:0] cur, logic r, logic e,
                                       logic d, logic l, logic [2:0] v);
    if (r) return 3'd0;
    if (l) return v;
    if (!e) return cur;
    if (!d) return 3'(up_seq[(pos_of(cur) + 1) % 8]);
    return 3'(up_seq[(pos_of(cur) + 7) % 8]);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_last(logic [2:0] a, logic d);
    return (!d && a == 3'd4) || (d && a == 3'd0) ? 1 : 0;
  endfunction

  // drive on negedge, clock in, compare on the following negedge
  task automatic cyc(logic r, logic e, logic d, logic l, logic [2:0] v, string req);
    rst = r; en = e; dir_down = d; load = l; load_addr = v;
    exp_addr = model(exp_addr, r, e, d, l, v);
    @(posedge clk);
    @(negedge clk);
    check(req, int'(addr), int'(exp_addr));
    check("R8", int'(last), exp_last(addr, dir_down));
  endtask

  initial begin
    rst = 1; en = 0; dir_down = 0; load = 0; load_addr = 0; exp_addr = 0;
    @(negedge clk);
    cyc(1, 0, 0, 0, 0, "R1");
    // R2 / R4: two full up passes from zero
    for (int k = 0; k < 16; k++) begin
      cyc(0, 1, 0, 0, 0, "R2");
      check("R4", int'(addr), up_seq[(k + 1) % 8]);
    end
    // R3 / R4: reverse passes from 4
    cyc(0, 0, 0, 1, 3'd4, "R7");
    for (int k = 0; k < 16; k++) begin
      cyc(0, 1, 1, 0, 0, "R3");
      check("R4", int'(addr), up_seq[(6 - (k % 8) + 8) % 8]);
    end
    // R6: hold in both directions from every start
    for (int s = 0; s < 8; s++) begin
      cyc(0, 0, 0, 1, 3'(s), "R7");
      cyc(0, 0, 0, 0, 0, "R6");
      cyc(0, 0, 1, 0, 0, "R6");
    end
    // R5: up then down from every start
    for (int s = 0; s < 8; s++) begin
      cyc(0, 1, 1, 1, 3'(s), "R7");
      cyc(0, 1, 0, 0, 0, "R2");
      cyc(0, 1, 1, 0, 0, "R5");
      check("R5", int'(addr), s);
    end
    // R1 over load
    cyc(1, 1, 0, 1, 3'd6, "R1");
    // mixed stimulus
    for (int k = 0; k < 400; k++) begin
      logic [5:0] rv;
      rv = 6'($urandom);
      cyc(rv[5] & rv[4] & rv[3], rv[0] | rv[1], rv[2], rv[3] & rv[4] & ~rv[5],
          3'($urandom), "R7");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule